// File: doc/BRIEF.md
# Configuration Port Key Lock

This block is the configuration-space responder behind a two-byte I/O window: an index port at the window base and a data port one address above it. After reset it refuses all configuration traffic. Software opens it by writing the entry key twice in a row to the index port, and closes it again with a single exit key. While open, a write to the index port picks a register and the data port reads or writes that register.

The open window shows global identity registers: a logical-device selector, a 16-bit device identifier, a revision byte and a 16-bit vendor identifier. It also shows a bank of per-device registers that exist only for the hardware-monitor logical device: an activate bit and a 16-bit base address. Those two values drive the `mon_active` and `mon_base` outputs, which the monitor function uses to claim its own I/O range. A strap parameter moves the whole window between two bases.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, `mon_active` is 0, `mon_base` is 0x0000, and a read of either port returns 0xFF.
- R2: The block unlocks only when 0x87 is written to the index port on two consecutive index writes; `unlocked` is high right after the clock edge that takes the second key.
- R3: An index write of any value other than 0x87 between the two key writes restarts the key detector, so 0x87, 0x12, 0x87 leaves the block locked.
- R4: Writing 0xAA to the index port while unlocked locks the block at the next edge; the exit key is not stored as an index.
- R5: While locked, data-port writes have no effect on any register and data-port reads return 0xFF; register contents persist across lock and unlock.
- R6: Only the window base (0x2E with `ALT_BASE`=0, 0x4E with `ALT_BASE`=1) and base+1 respond; key writes to any other address leave the block locked.
- R7: A read strobe at a clock edge updates `io_rdata` at that edge with the register chosen by the last stored index; an index-port read while unlocked returns the stored index.
- R8: Index 0x20 reads 0x04 and 0x21 reads 0x06 (device ID 0x0406, high byte first), 0x22 reads the revision (default 0x01), 0x23 reads 0x19 and 0x24 reads 0x34 (vendor ID 0x1934, high byte first); unimplemented indices read 0x00.
- R9: Index 0x07 is a read/write 8-bit logical-device selector, reset 0x00.
- R10: With selector 0x04, index 0x30 bit 0 is the activate bit (upper bits read 0) and indices 0x60/0x61 hold the base address high/low byte; `mon_active` and `mon_base` follow the next edge after the write.
- R11: With any other selector value, indices 0x30, 0x60 and 0x61 read 0x00 and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| unlocked | output | 1 | Configuration window is open |
| mon_active | output | 1 | Monitor device activate bit |
| mon_base | output | 16 | Monitor device base address |

## Verification
Key sequences are tried in three shapes: a clean double entry key, an entry key broken by a stray index value, and correct keys sent to a foreign address; these separate a detector that counts any two keys from one that needs them back to back at the right port. A table of register accesses then walks identity reads, selector writes and monitor-bank writes with the monitor bank both selected and deselected, which shows whether the bank decode depends on the selector. Finally the window is closed, written through the data port and reopened, showing that locked writes are dropped and that contents survive the lock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] KEY_ENTER = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_EXIT  = 8'hAA;
  localparam logic [BYTE_W-1:0] LOCKED_RD = 8'hFF;

  // Register indices
  localparam logic [BYTE_W-1:0] IX_LDSEL  = 8'h07;
  localparam logic [BYTE_W-1:0] IX_DEV_HI = 8'h20;
  localparam logic [BYTE_W-1:0] IX_DEV_LO = 8'h21;
  localparam logic [BYTE_W-1:0] IX_REV    = 8'h22;
  localparam logic [BYTE_W-1:0] IX_VEN_HI = 8'h23;
  localparam logic [BYTE_W-1:0] IX_VEN_LO = 8'h24;
  localparam logic [BYTE_W-1:0] IX_ACT    = 8'h30;
  localparam logic [BYTE_W-1:0] IX_BASE_H = 8'h60;
  localparam logic [BYTE_W-1:0] IX_BASE_L = 8'h61;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } key_state_e;

  function automatic logic [15:0] window_base(input bit alt);
    return alt ? 16'h004E : 16'h002E;
  endfunction

  // Readback value of one configuration register
  function automatic logic [BYTE_W-1:0] cfg_read(
    input logic [BYTE_W-1:0] idx,
    input logic [BYTE_W-1:0] ldn,
    input logic [BYTE_W-1:0] mon_ldn,
    input logic              act,
    input logic [15:0]       base,
    input logic [15:0]       dev_id,
    input logic [BYTE_W-1:0] rev,
    input logic [15:0]       ven_id
  );
    logic bank;
    bank = (ldn == mon_ldn);
    case (idx)
      IX_LDSEL:  return ldn;
      IX_DEV_HI: return dev_id[15:8];
      IX_DEV_LO: return dev_id[7:0];
      IX_REV:    return rev;
      IX_VEN_HI: return ven_id[15:8];
      IX_VEN_LO: return ven_id[7:0];
      IX_ACT:    return bank ? {7'd0, act} : 8'h00;
      IX_BASE_H: return bank ? base[15:8] : 8'h00;
      IX_BASE_L: return bank ? base[7:0] : 8'h00;
      default:   return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              unlocked,
  output logic              key_enter,
  output logic              key_exit
);

  key_state_e state_q, state_d;

  assign key_enter = (state_q == KS_HALF) && idx_wr && (wdata == KEY_ENTER);
  assign key_exit  = (state_q == KS_OPEN) && idx_wr && (wdata == KEY_EXIT);
  assign unlocked  = (state_q == KS_OPEN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      KS_IDLE: if (idx_wr && wdata == KEY_ENTER) state_d = KS_HALF;
      KS_HALF: if (idx_wr) state_d = (wdata == KEY_ENTER) ? KS_OPEN : KS_IDLE;
      KS_OPEN: if (key_exit) state_d = KS_IDLE;
      default: state_d = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] MON_LDN = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              dat_wr,
  input  logic              unlocked,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] index,
  output logic [BYTE_W-1:0] ldn,
  output logic              mon_active,
  output logic [15:0]       mon_base
);

  logic store_idx, store_dat, bank_sel;

  assign store_idx = idx_wr && unlocked && (wdata != KEY_EXIT);
  assign store_dat = dat_wr && unlocked;
  assign bank_sel  = (ldn == MON_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index      <= '0;
      ldn        <= '0;
      mon_active <= 1'b0;
      mon_base   <= '0;
    end else begin
      if (store_idx) index <= wdata;
      if (store_dat) begin
        if (index == IX_LDSEL) ldn <= wdata;
        if (bank_sel) begin
          if (index == IX_ACT)    mon_active     <= wdata[0];
          if (index == IX_BASE_H) mon_base[15:8] <= wdata;
          if (index == IX_BASE_L) mon_base[7:0]  <= wdata;
        end
      end
    end
  end

endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0]  MON_LDN   = 8'h04,
  parameter logic [15:0] DEV_ID    = 16'h0406,
  parameter logic [7:0]  REVISION  = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic [BYTE_W-1:0] index,
  input  logic [BYTE_W-1:0] ldn,
  input  logic              mon_active,
  input  logic [15:0]       mon_base,
  output logic [BYTE_W-1:0] sel_data
);

  always_comb
    sel_data = cfg_read(index, ldn, MON_LDN, mon_active, mon_base,
                        DEV_ID, REVISION, VENDOR_ID);

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter bit          ALT_BASE  = 1'b0,
  parameter logic [7:0]  MON_LDN   = 8'h04,
  parameter logic [15:0] DEV_ID    = 16'h0406,
  parameter logic [7:0]  REVISION  = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              unlocked,
  output logic              mon_active,
  output logic [15:0]       mon_base
);

  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(window_base(ALT_BASE));
  localparam logic [ADDR_W-1:0] DAT_PORT = IDX_PORT + ADDR_W'(1);

  logic hit_idx, hit_dat;
  logic idx_wr, dat_wr, idx_rd, dat_rd;
  logic key_enter, key_exit;
  logic [BYTE_W-1:0] index, ldn, sel_data;

  assign hit_idx = (io_addr == IDX_PORT);
  assign hit_dat = (io_addr == DAT_PORT);
  assign idx_wr  = io_wr && hit_idx;
  assign dat_wr  = io_wr && hit_dat;
  assign idx_rd  = io_rd && hit_idx;
  assign dat_rd  = io_rd && hit_dat;

  sio_key_fsm u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .wdata     (io_wdata),
    .unlocked  (unlocked),
    .key_enter (key_enter),
    .key_exit  (key_exit)
  );

  sio_cfg_regs #(.MON_LDN(MON_LDN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (idx_wr),
    .dat_wr     (dat_wr),
    .unlocked   (unlocked),
    .wdata      (io_wdata),
    .index      (index),
    .ldn        (ldn),
    .mon_active (mon_active),
    .mon_base   (mon_base)
  );

  sio_cfg_rdmux #(
    .MON_LDN   (MON_LDN),
    .DEV_ID    (DEV_ID),
    .REVISION  (REVISION),
    .VENDOR_ID (VENDOR_ID)
  ) u_rdmux (
    .index      (index),
    .ldn        (ldn),
    .mon_active (mon_active),
    .mon_base   (mon_base),
    .sel_data   (sel_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      io_rdata <= LOCKED_RD;
    else if (dat_rd) io_rdata <= unlocked ? sel_data : LOCKED_RD;
    else if (idx_rd) io_rdata <= unlocked ? index : LOCKED_RD;
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        idx_wr,
  input logic        dat_rd,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        unlocked,
  input logic        key_enter,
  input logic        key_exit,
  input logic        mon_active,
  input logic [15:0] mon_base
);

  a_r2_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    key_enter |=> unlocked);

  a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && io_wdata == KEY_ENTER));

  a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    key_exit |=> !unlocked);

  a_r5_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !unlocked) |=> io_rdata == LOCKED_RD);

  a_r5_locked_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(mon_base));

  a_r5_locked_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(mon_active));

endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idx_wr     (idx_wr),
  .dat_rd     (dat_rd),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .unlocked   (unlocked),
  .key_enter  (key_enter),
  .key_exit   (key_exit),
  .mon_active (mon_active),
  .mon_base   (mon_base)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

  localparam logic [15:0] IXP = 16'h002E;
  localparam logic [15:0] DTP = 16'h002F;
  localparam int NVEC = 17;

  // {write, index, data-or-expected}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'h20, 8'h04},   // R8 device id high
    {1'b0, 8'h21, 8'h06},   // R8 device id low
    {1'b0, 8'h22, 8'h01},   // R8 revision
    {1'b0, 8'h23, 8'h19},   // R8 vendor high
    {1'b0, 8'h24, 8'h34},   // R8 vendor low
    {1'b0, 8'h25, 8'h00},   // R8 unimplemented
    {1'b0, 8'h07, 8'h00},   // R9 reset selector
    {1'b1, 8'h07, 8'h04},   // R9 select monitor
    {1'b0, 8'h07, 8'h04},   // R9 readback
    {1'b1, 8'h30, 8'hFF},   // R10 activate
    {1'b0, 8'h30, 8'h01},   // R10 only bit 0
    {1'b1, 8'h60, 8'h0A},   // R10 base high
    {1'b1, 8'h61, 8'h90},   // R10 base low
    {1'b1, 8'h07, 8'h02},   // R11 other device
    {1'b1, 8'h60, 8'h33},   // R11 dropped write
    {1'b0, 8'h60, 8'h00},   // R11 bank hidden
    {1'b0, 8'h30, 8'h00}    // R11 bank hidden
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        unlocked, mon_active;
  logic [15:0] mon_base;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .unlocked(unlocked), .mon_active(mon_active), .mon_base(mon_base)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 unlocked", {15'd0, unlocked}, 16'd0);
    check("R1 active", {15'd0, mon_active}, 16'd0);
    check("R1 base", mon_base, 16'h0000);
    rd(DTP, v); check("R1 data read", {8'd0, v}, 16'h00FF);
    rd(IXP, v); check("R1 index read", {8'd0, v}, 16'h00FF);

    // R6 keys at a foreign address
    wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
    check("R6 foreign keys", {15'd0, unlocked}, 16'd0);

    // R3 broken key
    wr(IXP, 8'h87); wr(IXP, 8'h12); wr(IXP, 8'h87);
    check("R3 broken key", {15'd0, unlocked}, 16'd0);
    // R2 one more key completes the pair
    wr(IXP, 8'h87);
    check("R2 unlocked", {15'd0, unlocked}, 16'd1);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(IXP, VEC[i][15:8]);
      if (VEC[i][16]) wr(DTP, VEC[i][7:0]);
      else begin
        rd(DTP, v);
        check($sformatf("R7 vec%0d idx 0x%0h", i, VEC[i][15:8]), {8'd0, v}, {8'd0, VEC[i][7:0]});
      end
    end

    // R10 outputs
    check("R10 active out", {15'd0, mon_active}, 16'd1);
    check("R10 base out", mon_base, 16'h0A90);
    wr(IXP, 8'h07); wr(DTP, 8'h04);
    wr(IXP, 8'h61); rd(DTP, v);
    check("R10 base low read", {8'd0, v}, 16'h0090);
    // R7 index port readback
    rd(IXP, v); check("R7 index read", {8'd0, v}, 16'h0061);

    // R4 exit
    wr(IXP, 8'hAA);
    check("R4 locked", {15'd0, unlocked}, 16'd0);
    // R5 locked access
    wr(DTP, 8'h00);
    check("R5 base held", mon_base, 16'h0A90);
    rd(DTP, v); check("R5 locked read", {8'd0, v}, 16'h00FF);

    // reopen: R4 exit key not stored, R5 contents persist
    wr(IXP, 8'h87); wr(IXP, 8'h87);
    check("R2 reopen", {15'd0, unlocked}, 16'd1);
    rd(IXP, v); check("R4 index kept", {8'd0, v}, 16'h0061);
    rd(DTP, v); check("R5 persist", {8'd0, v}, 16'h0090);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

endmodule